// File: doc/BRIEF.md
# Serial Door Motor Controller

This block takes door commands from a host over a three-wire serial link (a frame select, a bit clock and a data line) and turns each command into drive signals for a door motor. A command is five bits long. One bit says whether the door is to be opened or closed, and the other four bits give the motor speed. The serial side is built from a small control state machine, a shift register and a bit counter. When a frame is complete, the received word is held until the motor side reports that the command is finished.

The motor side asserts a run enable, a direction and the held speed until the limit sensor for the requested end position becomes active. A close is interrupted if someone stands in the doorway. The door is then driven open again, and it is closed automatically once the doorway is clear, without a further command from the host. A busy output stays high from the end of a frame until the whole command, including any reopen and reclose, is done. When busy is low the host may send the next command.

Top module: `door_cmd_ctrl`

## Requirements
- R1: While `cmd_sel_n` is low, each rising edge of `cmd_sclk` captures one bit from `cmd_sdat`. The first captured bit is the direction flag (1 = open, 0 = close). The next four bits are the speed, most significant bit first. Bits after the fifth are ignored. A frame with five or more bits is accepted when `cmd_sel_n` returns high.
- R2: After reset `busy` is 0. `busy` reads 1 in the cycle after the clock edge that sees `cmd_sel_n` high at the end of an accepted frame. It returns to 0 only after the command has completed.
- R3: For an open command, `mtr_on`=1 and `mtr_dir`=1, with `mtr_speed` equal to the commanded speed, until `lim_open` is seen. `mtr_on` drops in the same cycle that `lim_open` is high. `mtr_speed` reads 0 whenever `mtr_on` is 0.
- R4: For a close command, `mtr_on`=1 and `mtr_dir`=0, with the commanded speed, until `lim_closed` is seen. `mtr_on` drops in that same cycle.
- R5: If `person` is high while the door is closing and `lim_closed` is low, the drive reverses on the next clock edge (`mtr_dir`=1) and the door is driven open.
- R6: After such a reopen reaches `lim_open`, the motor stays off while `person` remains high. One clock edge after `person` goes low, closing resumes with the original speed and no new frame. `busy` stays 1 throughout.
- R7: If the door is already at the requested limit when a command is taken, the command completes without `mtr_on` ever going high, and `busy` returns to 0.
- R8: `person` has no effect while the door is opening or while the block is idle.
- R9: A frame that ends with fewer than five bits is discarded. `busy` stays 0 and the motor does not move.
- R10: A frame sent while `busy` is 1 is ignored. It causes no motor action after the current command ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_sel_n | input | 1 | Frame select from the host, active low |
| cmd_sclk | input | 1 | Serial bit clock, synchronous to clk; bits are captured on its rising edge |
| cmd_sdat | input | 1 | Serial data bit |
| lim_open | input | 1 | Fully-open limit sensor, active high |
| lim_closed | input | 1 | Fully-closed limit sensor, active high |
| person | input | 1 | Person-in-doorway sensor, active high |
| mtr_on | output | 1 | Motor run enable |
| mtr_dir | output | 1 | Motor direction, 1 = opening, 0 = closing |
| mtr_speed | output | 4 | Motor speed, 0 while the motor is off |
| busy | output | 1 | High while a command is held or in progress |

## Verification
The hardest path to reach is the interrupted close. It needs a close already in motion, the person sensor raised partway through, the open limit reached while the sensor is still high, and then the sensor released, all within one busy window. A directed task walks the sensors through this order one step at a time. It checks that the drive reverses one edge after the person sensor rises, that the motor stays off for several cycles while the doorway is occupied, and that closing resumes at the original speed one edge after the doorway clears. Frames sent while busy, and frames that are too short, are covered by further tasks that then watch the motor and busy outputs for many cycles.

// File: rtl/door_pkg.sv
package door_pkg;
    localparam int SPEED_W = 4;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_HOLD  = 2'd2
    } rx_state_e;

    typedef enum logic [2:0] {
        MT_IDLE   = 3'd0,
        MT_OPEN   = 3'd1,
        MT_CLOSE  = 3'd2,
        MT_REOPEN = 3'd3,
        MT_WAIT   = 3'd4
    } mt_state_e;
endpackage

// File: rtl/door_rx.sv
module door_rx
    import door_pkg::*;
#(
    parameter int SPEED_W = door_pkg::SPEED_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n,
    input  logic               sclk,
    input  logic               sdat,
    input  logic               done,
    output logic               word_vld,
    output logic               word_open,
    output logic [SPEED_W-1:0] word_speed,
    output logic               busy
);
    localparam int FRAME_BITS = SPEED_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

    typedef struct packed {
        rx_state_e             st;
        logic                  sclk;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] shreg;
    } rx_regs_t;

    rx_regs_t r_q, r_d;
    logic     rise;

    always_comb begin
        r_d      = r_q;
        rise     = sclk & ~r_q.sclk;
        r_d.sclk = sclk;
        case (r_q.st)
            RX_IDLE: begin
                if (!sel_n) begin
                    r_d.st  = RX_SHIFT;
                    r_d.cnt = '0;
                end
            end
            RX_SHIFT: begin
                if (sel_n) begin
                    r_d.st = (r_q.cnt == FULL) ? RX_HOLD : RX_IDLE;
                end else if (rise && (r_q.cnt != FULL)) begin
                    r_d.shreg = {r_q.shreg[FRAME_BITS-2:0], sdat};
                    r_d.cnt   = r_q.cnt + 1'b1;
                end
            end
            RX_HOLD: begin
                if (done) r_d.st = RX_IDLE;
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= RX_IDLE;
            r_q.sclk  <= 1'b0;
            r_q.cnt   <= '0;
            r_q.shreg <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_vld   = (r_q.st == RX_HOLD);
    assign busy       = word_vld;
    assign word_open  = r_q.shreg[FRAME_BITS-1];
    assign word_speed = r_q.shreg[SPEED_W-1:0];

    // R2: completion releases the held word on the next edge
    p_busy_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy);

    // R10: a held word cannot be disturbed by new serial traffic
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(word_speed) && $stable(word_open) && busy));
endmodule

// File: rtl/door_motor.sv
module door_motor
    import door_pkg::*;
#(
    parameter int SPEED_W = door_pkg::SPEED_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_vld,
    input  logic               cmd_open,
    input  logic [SPEED_W-1:0] cmd_speed,
    input  logic               lim_open,
    input  logic               lim_closed,
    input  logic               person,
    output logic               done,
    output logic               mtr_on,
    output logic               mtr_dir,
    output logic [SPEED_W-1:0] mtr_speed
);
    typedef struct packed {
        mt_state_e          st;
        logic [SPEED_W-1:0] spd;
    } mt_regs_t;

    mt_regs_t m_q, m_d;
    logic     drive_open;

    always_comb begin
        m_d  = m_q;
        done = 1'b0;
        case (m_q.st)
            MT_IDLE: begin
                if (cmd_vld) begin
                    m_d.spd = cmd_speed;
                    if (cmd_open) begin
                        if (lim_open) done = 1'b1;
                        else          m_d.st = MT_OPEN;
                    end else begin
                        if (lim_closed) done = 1'b1;
                        else            m_d.st = MT_CLOSE;
                    end
                end
            end
            MT_OPEN: begin
                if (lim_open) begin
                    done   = 1'b1;
                    m_d.st = MT_IDLE;
                end
            end
            MT_CLOSE: begin
                if (lim_closed) begin
                    done   = 1'b1;
                    m_d.st = MT_IDLE;
                end else if (person) begin
                    m_d.st = MT_REOPEN;
                end
            end
            MT_REOPEN: begin
                if (lim_open) m_d.st = MT_WAIT;
            end
            MT_WAIT: begin
                if (!person) m_d.st = MT_CLOSE;
            end
            default: m_d.st = MT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.st  <= MT_IDLE;
            m_q.spd <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign drive_open = (m_q.st == MT_OPEN) || (m_q.st == MT_REOPEN);
    assign mtr_on     = (drive_open && !lim_open) ||
                        ((m_q.st == MT_CLOSE) && !lim_closed);
    assign mtr_dir    = drive_open;
    assign mtr_speed  = mtr_on ? m_q.spd : '0;

    // R5: a person seen while closing reverses the drive on the next edge
    p_abort_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mtr_on && !mtr_dir && person) |=> mtr_dir);

    // R6: a clear doorway after the reopen resumes closing
    p_auto_reclose_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st == MT_WAIT && !person) |=> (m_q.st == MT_CLOSE));

    // R8: an open in progress is not disturbed by the person sensor
    p_open_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st == MT_OPEN && !lim_open) |=> (m_q.st == MT_OPEN));

    // R3: speed is kept for the whole command
    p_speed_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st != MT_IDLE) |=> $stable(m_q.spd));
endmodule

// File: rtl/door_cmd_ctrl.sv
module door_cmd_ctrl
    import door_pkg::*;
#(
    parameter int SPEED_W = door_pkg::SPEED_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_sel_n,
    input  logic               cmd_sclk,
    input  logic               cmd_sdat,
    input  logic               lim_open,
    input  logic               lim_closed,
    input  logic               person,
    output logic               mtr_on,
    output logic               mtr_dir,
    output logic [SPEED_W-1:0] mtr_speed,
    output logic               busy
);
    logic               w_vld;
    logic               w_open;
    logic [SPEED_W-1:0] w_speed;
    logic               w_done;

    door_rx #(.SPEED_W(SPEED_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (cmd_sel_n),
        .sclk       (cmd_sclk),
        .sdat       (cmd_sdat),
        .done       (w_done),
        .word_vld   (w_vld),
        .word_open  (w_open),
        .word_speed (w_speed),
        .busy       (busy)
    );

    door_motor #(.SPEED_W(SPEED_W)) u_mt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_vld    (w_vld),
        .cmd_open   (w_open),
        .cmd_speed  (w_speed),
        .lim_open   (lim_open),
        .lim_closed (lim_closed),
        .person     (person),
        .done       (w_done),
        .mtr_on     (mtr_on),
        .mtr_dir    (mtr_dir),
        .mtr_speed  (mtr_speed)
    );

    // R3: the motor only runs inside a busy window
    p_drive_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mtr_on |-> busy);

    // R7: completion is only reported for a held command
    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        w_done |-> busy);
endmodule

// File: tb/sim_door_cmd_ctrl.sv
module sim_door_cmd_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
    logic       lo = 1'b0, lc = 1'b1, pers = 1'b0;
    logic       on, dir, busy;
    logic [3:0] spd;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    door_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_sel_n(sel_n), .cmd_sclk(sclk),
        .cmd_sdat(sdat), .lim_open(lo), .lim_closed(lc), .person(pers),
        .mtr_on(on), .mtr_dir(dir), .mtr_speed(spd), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic send(input bit op, input logic [3:0] sp, input int nbits);
        @(negedge clk);
        sel_n = 1'b0;
        cyc(2);
        for (int i = 0; i < nbits; i++) begin
            sdat = (i == 0) ? op : (i < 5) ? sp[4-i] : ~op;
            cyc(2);
            sclk = 1'b1;
            cyc(2);
            sclk = 1'b0;
        end
        cyc(2);
        @(negedge clk);
        sel_n = 1'b1;
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R2 reset busy", busy, 0);
        chk(on == 1'b0, "R2 reset mtr_on", on, 0);
        chk(spd == 4'd0, "R3 reset speed", spd, 0);
    endtask

    task automatic t_open;
        lc = 1'b1; lo = 1'b0;
        send(1'b1, 4'd9, 5);
        cyc(1);
        chk(busy == 1'b1, "R2 busy after frame", busy, 1);
        cyc(1);
        chk(on && dir, "R3 opening drive", {on, dir}, 3);
        chk(spd == 4'd9, "R1 speed field", spd, 9);
        lc = 1'b0; pers = 1'b1;
        cyc(3);
        chk(on && dir, "R8 person ignored while opening", {on, dir}, 3);
        pers = 1'b0;
        lo = 1'b1;
        #1;
        chk(on == 1'b0, "R3 stop at open limit same cycle", on, 0);
        chk(spd == 4'd0, "R3 speed zero when off", spd, 0);
        cyc(1);
        chk(busy == 1'b0, "R2 busy released", busy, 0);
    endtask

    task automatic t_close_extra_bits;
        lo = 1'b1; lc = 1'b0;
        send(1'b0, 4'd5, 6);
        cyc(2);
        chk(on && !dir, "R4 closing drive", {on, dir}, 2);
        chk(spd == 4'd5, "R1 extra bit ignored", spd, 5);
        lo = 1'b0;
        cyc(3);
        lc = 1'b1;
        #1;
        chk(on == 1'b0, "R4 stop at closed limit", on, 0);
        cyc(1);
        chk(busy == 1'b0, "R4 close completes", busy, 0);
    endtask

    task automatic t_person;
        lo = 1'b1; lc = 1'b0;
        send(1'b0, 4'd3, 5);
        cyc(2);
        lo = 1'b0;
        chk(on && !dir, "R5 close started", {on, dir}, 2);
        cyc(2);
        pers = 1'b1;
        #1;
        chk(!dir, "R5 no reversal before edge", dir, 0);
        cyc(1);
        chk(on && dir, "R5 reversed to open", {on, dir}, 3);
        cyc(3);
        lo = 1'b1;
        #1;
        chk(on == 1'b0, "R6 stop at open while person", on, 0);
        cyc(5);
        chk(on == 1'b0, "R6 waits while doorway occupied", on, 0);
        chk(busy == 1'b1, "R6 busy held during wait", busy, 1);
        pers = 1'b0;
        cyc(1);
        chk(on && !dir, "R6 automatic reclose", {on, dir}, 2);
        chk(spd == 4'd3, "R6 reclose keeps speed", spd, 3);
        lo = 1'b0;
        cyc(3);
        lc = 1'b1;
        cyc(1);
        chk(busy == 1'b0, "R6 reclose completes", busy, 0);
    endtask

    task automatic t_at_limit(input bit op);
        bit moved;
        lo = op; lc = ~op;
        send(op, 4'd11, 5);
        moved = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cyc(1);
            if (on) moved = 1'b1;
        end
        chk(!moved, "R7 no drive at limit", moved, 0);
        chk(busy == 1'b0, "R7 busy released at limit", busy, 0);
    endtask

    task automatic t_short;
        bit seen;
        lo = 1'b0; lc = 1'b1;
        send(1'b1, 4'd6, 3);
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (busy || on) seen = 1'b1;
        end
        chk(!seen, "R9 short frame discarded", seen, 0);
        send(1'b1, 4'd6, 5);
        cyc(2);
        chk(on && spd == 4'd6, "R9 next full frame accepted", spd, 6);
        lc = 1'b0;
        lo = 1'b1;
        cyc(1);
        chk(busy == 1'b0, "R9 full frame completes", busy, 0);
    endtask

    task automatic t_busy_ignore;
        bit seen;
        lo = 1'b0; lc = 1'b1;
        send(1'b1, 4'd2, 5);
        cyc(2);
        lc = 1'b0;
        send(1'b0, 4'd7, 5);
        cyc(1);
        chk(on && dir && spd == 4'd2, "R10 running command unchanged", spd, 2);
        lo = 1'b1;
        cyc(1);
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (busy || on) seen = 1'b1;
        end
        chk(!seen, "R10 frame during busy ignored", seen, 0);
    endtask

    task automatic t_idle_person;
        bit seen;
        seen = 1'b0;
        pers = 1'b1;
        for (int i = 0; i < 5; i++) begin
            cyc(1);
            if (busy || on) seen = 1'b1;
        end
        pers = 1'b0;
        cyc(1);
        chk(!seen, "R8 person ignored while idle", seen, 0);
    endtask

    initial begin
        fork
            begin
                cyc(3);
                t_reset();
                rst_n = 1'b1;
                cyc(2);
                t_reset();
                t_open();
                t_close_extra_bits();
                t_person();
                t_at_limit(1'b0);
                t_at_limit(1'b1);
                t_short();
                t_busy_ignore();
                t_idle_person();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule